// File: doc/BRIEF.md
# Maskable Dual Time-of-Day Alarm with Interrupt Routing

This block holds two time-of-day alarms. Each alarm has four byte registers: seconds, minutes, hours and day. Bit 7 of every alarm byte is a mask, and a masked field drops out of the comparison. The mask pattern therefore sets how often an alarm repeats:

- all four masked: every second;
- only seconds compared: once a minute;
- seconds and minutes compared: once an hour;
- all but the day compared: once a day;
- nothing masked: once a week.

An external timekeeper supplies the live time as four BCD bytes together with a one-cycle update strobe. On each strobe the block compares both alarms with the live time. A match sets that alarm's flag.

A control register stores a stop bit, a write-protect bit, a routing bit and one interrupt enable per alarm. The two active-low interrupt lines follow the flags and the enables. With routing set, each alarm drives its own line. With routing clear, both alarms share line 0 and line 1 stays high.

A flag clears when software reads or writes any register of its alarm through the byte-wide register port. If a match arrives in the same cycle as such an access, the match wins and the flag stays set.

Top module: `tod_alarm_pair`

## Requirements
- R1: After reset all alarm bytes and the control register read 0, both flags are 0 and both interrupt lines are high.
- R2: A write to 87h, 88h, 89h or 8Ah loads the seconds, minutes, hours or day byte of alarm 0. A write to 8Bh, 8Ch, 8Dh or 8Eh loads the same bytes of alarm 1. Every byte reads back at its write address with bit 7 clear (07h to 0Eh).
- R3: The live time arrives on cur_time with seconds in bits 7:0, minutes in 15:8, hours in 23:16 and day in 31:24. An unmasked field matches when bits 6:0 of the alarm byte equal bits 6:0 of the live byte. Bit 7 of the live byte is ignored, and the hour encoding bits are compared exactly as stored.
- R4: An alarm whose four bytes all have bit 7 set matches on every update strobe, whatever the live time.
- R5: A flag is set only at a clock edge where tick is high and every field of that alarm matches. A matching time without tick leaves the flag unchanged.
- R6: While control bit 7 (stop) is 1, update strobes set no flag.
- R7: A read or write of any of an alarm's four registers clears that alarm's flag at that edge and leaves the other flag alone. A match in the same cycle wins and leaves the flag set.
- R8: With control bit 2 (routing) at 1, irq0_n is low exactly when flag 0 and control bit 0 are both 1, and irq1_n is low exactly when flag 1 and control bit 1 are both 1.
- R9: With routing at 0, irq0_n is low when either alarm's flag and enable are both 1, and irq1_n stays high.
- R10: The control register is written at 8Fh and read at 0Fh. Bits 5 to 3 always read 0.
- R11: While control bit 6 (write protect) is 1, writes to the alarm bytes are ignored, and a write to 8Fh changes only bit 6.
- R12: Reads of addresses outside 07h to 0Fh return 0. This includes write addresses presented on the read port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe marking a time update |
| cur_time | input | 32 | Live day, hours, minutes, seconds in BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address (bit 7 set) |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Read address (bit 7 clear) |
| rd_data | output | 8 | Read data, valid while rd_en is high |
| alarm_flag | output | 2 | Alarm flags, bit 0 for alarm 0 |
| irq0_n | output | 1 | Active-low interrupt line 0 |
| irq1_n | output | 1 | Active-low interrupt line 1 |

## Verification
The hardest case to reach is a register access to an alarm in the very cycle that alarm matches. There the match must beat the clear. The bench drives a read strobe and the update strobe from one task in the same cycle, with the live time set equal to the stored alarm. It then checks that the flag is still set.

The routing cases need both flags set at once. The two alarms cannot match on one time value, so the bench sets them with two separate strobes. It then walks the control register through the routing and enable combinations without touching the alarm registers, so neither flag is cleared along the way.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

   // Control register layout; positions are decoded by software
   typedef struct packed {
      logic       stop;     // bit 7: suppress compares
      logic       wp;       // bit 6: write protect
      logic [2:0] rsv;      // bits 5:3: read as zero
      logic       route;    // bit 2: 1 = one line per alarm
      logic       en1;      // bit 1: alarm 1 interrupt enable
      logic       en0;      // bit 0: alarm 0 interrupt enable
   } ctrl_t;

   localparam int CTRL_W     = 8;
   localparam int NUM_ALARMS = 2;

endpackage

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit #(
   parameter int DATA_W     = 8,
   parameter int NUM_FIELDS = 4,
   parameter int ADDR_W     = 8,
   parameter int BASE       = 7
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic                         wr_allow,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic                         rd_en,
   input  logic [ADDR_W-1:0]            rd_addr,
   input  logic [NUM_FIELDS*DATA_W-1:0] cur_time,
   input  logic                         upd,
   output logic                         flag,
   output logic [DATA_W-1:0]            rd_val
);

   localparam int OFF_W = ADDR_W - 1;
   localparam int MSB   = DATA_W - 1;

   logic [DATA_W-1:0]     fld_q [NUM_FIELDS];
   logic [NUM_FIELDS-1:0] fld_match;
   logic [NUM_FIELDS-1:0] wr_sel;
   logic [NUM_FIELDS-1:0] rd_sel;
   logic [NUM_FIELDS-1:0] time_msb_unused;
   logic                  access;
   logic                  fire;

   genvar f;
   for (f = 0; f < NUM_FIELDS; f++) begin : g_field
      localparam logic [OFF_W-1:0] OFS = OFF_W'(BASE + f);
      assign wr_sel[f] = wr_en && wr_addr[ADDR_W-1] && (wr_addr[OFF_W-1:0] == OFS);
      assign rd_sel[f] = rd_en && !rd_addr[ADDR_W-1] && (rd_addr[OFF_W-1:0] == OFS);
      assign fld_match[f] = fld_q[f][MSB] ||
                            (fld_q[f][MSB-1:0] == cur_time[f*DATA_W +: DATA_W-1]);
      assign time_msb_unused[f] = cur_time[f*DATA_W + MSB];

      AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_sel[f] && !wr_allow) |=> $stable(fld_q[f])); // R11
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_FIELDS; i++) fld_q[i] <= '0;
      end else if (wr_allow) begin
         for (int i = 0; i < NUM_FIELDS; i++)
            if (wr_sel[i]) fld_q[i] <= wr_data;
      end
   end

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < NUM_FIELDS; i++)
         if (rd_sel[i]) rd_val = rd_val | fld_q[i];
   end

   assign access = (|wr_sel) || (|rd_sel);
   assign fire   = upd && (&fld_match);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag <= 1'b0;
      else if (fire)   flag <= 1'b1;
      else if (access) flag <= 1'b0;
   end

   AST_SET_NEEDS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(upd)); // R5

   AST_CLEAR_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (access && !upd) |=> !flag); // R7

   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!access && !upd) |=> $stable(flag)); // R7

endmodule

// File: rtl/tod_alarm_ctrl.sv
module tod_alarm_ctrl
   import tod_alarm_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int OFFSET = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              stop,
   output logic              wr_allow,
   output logic              route,
   output logic [1:0]        en,
   output logic [CTRL_W-1:0] rd_val
);

   localparam int OFF_W = ADDR_W - 1;
   localparam logic [OFF_W-1:0] OFS = OFF_W'(OFFSET);

   ctrl_t ctrl_q;
   ctrl_t wr_view;
   logic  wr_sel;
   logic  rd_sel;
   logic  ctl_rsv_unused;

   assign wr_view        = ctrl_t'(wr_data);
   assign ctl_rsv_unused = ^wr_view.rsv;
   assign wr_sel = wr_en && wr_addr[ADDR_W-1] && (wr_addr[OFF_W-1:0] == OFS);
   assign rd_sel = rd_en && !rd_addr[ADDR_W-1] && (rd_addr[OFF_W-1:0] == OFS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_sel) begin
         ctrl_q.wp <= wr_view.wp;
         if (!ctrl_q.wp) begin
            ctrl_q.stop  <= wr_view.stop;
            ctrl_q.route <= wr_view.route;
            ctrl_q.en1   <= wr_view.en1;
            ctrl_q.en0   <= wr_view.en0;
         end
      end
   end

   assign stop     = ctrl_q.stop;
   assign wr_allow = !ctrl_q.wp;
   assign route    = ctrl_q.route;
   assign en       = {ctrl_q.en1, ctrl_q.en0};
   assign rd_val   = rd_sel ? {ctrl_q.stop, ctrl_q.wp, 3'b000, ctrl_q.route,
                               ctrl_q.en1, ctrl_q.en0} : '0;

   AST_CTRL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel && ctrl_q.wp) |=> $stable({ctrl_q.stop, ctrl_q.route, ctrl_q.en1, ctrl_q.en0})); // R11

   AST_CTRL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel && !ctrl_q.wp) |=> (ctrl_q.en0 == $past(wr_data[0]))); // R10

endmodule

// File: rtl/tod_alarm_irq.sv
module tod_alarm_irq (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] flag,
   input  logic [1:0] en,
   input  logic       route,
   output logic       irq0_n,
   output logic       irq1_n
);

   logic [1:0] req;

   assign req = flag & en;

   always_comb begin
      if (route) begin
         irq0_n = !req[0];
         irq1_n = !req[1];
      end else begin
         irq0_n = !(|req);
         irq1_n = 1'b1;
      end
   end

   AST_LINE1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !route |-> irq1_n); // R9

   AST_LINE1_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !irq1_n |-> (flag[1] && en[1])); // R8

   AST_LINE0_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !irq0_n |-> ((flag[0] && en[0]) || (!route && flag[1] && en[1]))); // R8

endmodule

// File: rtl/tod_alarm_pair.sv
module tod_alarm_pair
   import tod_alarm_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int NUM_FIELDS = 4,
   parameter int ADDR_W     = 8,
   parameter int A0_OFS     = 7
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         tick,
   input  logic [NUM_FIELDS*DATA_W-1:0] cur_time,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic                         rd_en,
   input  logic [ADDR_W-1:0]            rd_addr,
   output logic [DATA_W-1:0]            rd_data,
   output logic [NUM_ALARMS-1:0]        alarm_flag,
   output logic                         irq0_n,
   output logic                         irq1_n
);

   localparam int CTRL_OFS = A0_OFS + NUM_ALARMS * NUM_FIELDS;

   if (DATA_W < CTRL_W) begin : g_bad_width
      $error("DATA_W must be at least the control register width");
   end
   if (NUM_FIELDS < 1) begin : g_bad_fields
      $error("NUM_FIELDS must be at least 1");
   end
   if (CTRL_OFS >= (1 << (ADDR_W - 1))) begin : g_bad_map
      $error("register map does not fit below the write flag bit");
   end

   logic              stop;
   logic              wr_allow;
   logic              route;
   logic [1:0]        en;
   logic              upd;
   logic [CTRL_W-1:0] ctrl_rd;
   logic [DATA_W-1:0] unit_rd [NUM_ALARMS];

   assign upd = tick && !stop;

   tod_alarm_ctrl #(
      .ADDR_W (ADDR_W),
      .OFFSET (CTRL_OFS)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data[CTRL_W-1:0]),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .stop     (stop),
      .wr_allow (wr_allow),
      .route    (route),
      .en       (en),
      .rd_val   (ctrl_rd)
   );

   genvar a;
   for (a = 0; a < NUM_ALARMS; a++) begin : g_alarm
      tod_alarm_unit #(
         .DATA_W     (DATA_W),
         .NUM_FIELDS (NUM_FIELDS),
         .ADDR_W     (ADDR_W),
         .BASE       (A0_OFS + a * NUM_FIELDS)
      ) u_unit (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_en),
         .wr_allow (wr_allow),
         .wr_addr  (wr_addr),
         .wr_data  (wr_data),
         .rd_en    (rd_en),
         .rd_addr  (rd_addr),
         .cur_time (cur_time),
         .upd      (upd),
         .flag     (alarm_flag[a]),
         .rd_val   (unit_rd[a])
      );
   end

   always_comb begin
      rd_data = DATA_W'(ctrl_rd);
      for (int i = 0; i < NUM_ALARMS; i++) rd_data = rd_data | unit_rd[i];
   end

   tod_alarm_irq u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .flag   (alarm_flag),
      .en     (en),
      .route  (route),
      .irq0_n (irq0_n),
      .irq1_n (irq1_n)
   );

   AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (alarm_flag & ~$past(alarm_flag)) == '0); // R6

endmodule

// File: tb/tod_alarm_pair_test.sv
`timescale 1ns/1ps
module tod_alarm_pair_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [31:0] cur_time = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_addr = '0;
   logic [7:0]  rd_data;
   logic [1:0]  alarm_flag;
   logic        irq0_n;
   logic        irq1_n;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tod_alarm_pair uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cur_time(cur_time),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .alarm_flag(alarm_flag), .irq0_n(irq0_n), .irq1_n(irq1_n)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
      rd_en = 1'b1; rd_addr = a;
      #1;
      chk(rd_data == exp, tag, rd_data, exp);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic pulse(input logic [31:0] t);
      cur_time = t; tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic load(input logic [7:0] base, input logic [31:0] v);
      for (int i = 0; i < 4; i++) wr(base + 8'(i), v[i*8 +: 8]);
   endtask

   task automatic t_reset();
      chk(alarm_flag == 2'b00, "R1 flags", alarm_flag, 0);
      chk(irq0_n && irq1_n, "R1 lines", {irq1_n, irq0_n}, 3);
      rd_chk(8'h0F, 8'h00, "R1 ctrl");
      rd_chk(8'h07, 8'h00, "R1 alarm byte");
   endtask

   task automatic t_regs();
      wr(8'h8F, 8'h3F);
      rd_chk(8'h0F, 8'h07, "R10 ctrl rsv bits zero");
      load(8'h87, 32'h44332211);
      load(8'h8B, 32'h01776655);
      for (int i = 0; i < 4; i++) begin
         rd_chk(8'h07 + 8'(i), 8'h11 * 8'(i + 1), "R2 alarm0 readback");
         rd_chk(8'h0B + 8'(i), (i == 3) ? 8'h01 : 8'h55 + 8'h11 * 8'(i), "R2 alarm1 readback");
      end
   endtask

   task automatic t_mask_all();
      load(8'h87, 32'h80808080);
      pulse(32'h12345678);
      chk(alarm_flag[0], "R4 all masked fires", alarm_flag, 1);
      chk(!alarm_flag[1], "R3 alarm1 no match", alarm_flag, 1);
      rd_chk(8'h07, 8'h80, "R2 masked byte");
      chk(!alarm_flag[0], "R7 read clears", alarm_flag, 0);
      pulse(32'h00000001);
      chk(alarm_flag[0], "R4 fires again", alarm_flag, 1);
   endtask

   task automatic t_full();
      load(8'h87, 32'h03081530);
      pulse(32'h04081530);
      chk(!alarm_flag[0], "R3 day mismatch", alarm_flag, 0);
      pulse(32'h030815B0);
      chk(alarm_flag[0], "R3 full match, live bit7 ignored", alarm_flag, 1);
   endtask

   task automatic t_sec_only();
      load(8'h8B, 32'h80808045);
      pulse(32'h12225945);
      chk(alarm_flag == 2'b11, "R3 seconds-only match", alarm_flag, 3);
   endtask

   task automatic t_no_tick();
      rd_chk(8'h08, 8'h15, "R2 minutes");
      cur_time = 32'h03081530;
      @(negedge clk);
      @(negedge clk);
      chk(!alarm_flag[0], "R5 no tick no flag", alarm_flag, 0);
   endtask

   task automatic t_stop();
      wr(8'h8F, 8'h87);
      pulse(32'h03081530);
      chk(!alarm_flag[0], "R6 stopped", alarm_flag, 0);
      wr(8'h8F, 8'h07);
      pulse(32'h03081530);
      chk(alarm_flag[0], "R6 running again", alarm_flag, 1);
   endtask

   task automatic t_clear();
      rd_chk(8'h0B, 8'h45, "R2 alarm1 seconds");
      chk(alarm_flag == 2'b01, "R7 only alarm1 cleared", alarm_flag, 1);
      wr(8'h87, 8'h30);
      chk(alarm_flag == 2'b00, "R7 write clears", alarm_flag, 0);
      cur_time = 32'h03081530; tick = 1'b1; rd_en = 1'b1; rd_addr = 8'h08;
      @(negedge clk);
      tick = 1'b0; rd_en = 1'b0;
      chk(alarm_flag[0], "R7 match beats clear", alarm_flag, 1);
   endtask

   task automatic t_irq();
      pulse(32'h00000045);
      chk(alarm_flag == 2'b11, "R8 both flags", alarm_flag, 3);
      chk(!irq0_n && !irq1_n, "R8 both lines low", {irq1_n, irq0_n}, 0);
      wr(8'h8F, 8'h06);
      chk(irq0_n && !irq1_n, "R8 line0 disabled", {irq1_n, irq0_n}, 1);
      wr(8'h8F, 8'h01);
      chk(!irq0_n && irq1_n, "R9 shared from alarm0", {irq1_n, irq0_n}, 2);
      wr(8'h8F, 8'h02);
      chk(!irq0_n && irq1_n, "R9 shared from alarm1", {irq1_n, irq0_n}, 2);
      rd_chk(8'h0C, 8'h80, "R2 alarm1 minutes");
      chk(irq0_n && irq1_n, "R9 released", {irq1_n, irq0_n}, 3);
      wr(8'h8F, 8'h00);
      chk(irq0_n && irq1_n, "R8 all disabled", {irq1_n, irq0_n}, 3);
   endtask

   task automatic t_wp();
      wr(8'h8F, 8'h47);
      wr(8'h87, 8'h99);
      rd_chk(8'h07, 8'h30, "R11 alarm write blocked");
      wr(8'h8F, 8'hC0);
      rd_chk(8'h0F, 8'h47, "R11 ctrl locked");
      wr(8'h8F, 8'h80);
      rd_chk(8'h0F, 8'h07, "R11 wp cleared only");
      wr(8'h87, 8'h99);
      rd_chk(8'h07, 8'h99, "R11 write accepted");
   endtask

   task automatic t_unused();
      rd_chk(8'h00, 8'h00, "R12 addr 00");
      rd_chk(8'h10, 8'h00, "R12 addr 10");
      rd_chk(8'h87, 8'h00, "R12 write addr on read port");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_mask_all();
      t_full();
      t_sec_only();
      t_no_tick();
      t_stop();
      t_clear();
      t_irq();
      t_wp();
      t_unused();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         chk(1'b0, "watchdog", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule